// File: doc/BRIEF.md
# Cascadable Serial-In Parallel-Out Display Driver

This block feeds a segmented or dot-matrix display from a single serial bit stream. On each rising clock edge one bit enters a chain of stages (12 by default), and every stored bit moves one stage further along. A bank of output holding registers copies the chain when a load request is high. This lets a new pattern be shifted in behind the visible one and then shown all at once. An active-low display-enable input lets the held pattern through to the segment outputs. When that input is high, every segment is forced off.

The tail stage of the chain also drives a serial output, and neither the load request nor the display enable affects it. Several drivers can therefore be chained, each one's serial output feeding the next one's data input. In a chain of N devices, a stream of N×STAGES bits leaves the first bit sent in the tail stage of the last device.

Top module: `sds_driver`

## Requirements
- R1: A synchronous active-high reset clears every shift stage and every holding register. After reset, `seg_q` is all zeros and `ser_out` is 0.
- R2: On each rising `clk` edge, stage 1 takes `ser_in` and each stage n>1 takes the old value of stage n-1. After STAGES edges, the first bit sent sits in the last stage.
- R3: `ser_out` always equals the last stage. Its value after shift k equals the bit sent at shift k-STAGES+1 (0 if fewer bits have been sent since reset), whatever `load_req` and `show_n` do.
- R4: At a rising edge with `load_req` high, holding register n takes the value stage n has just after that same edge. At an edge with `load_req` low, the holding registers keep their value.
- R5: Segment output `seg_q[n-1]` maps to stage n. While `show_n` is low, `seg_q` equals the holding registers. While `show_n` is high, `seg_q` is all zeros.
- R6: Toggling `show_n` with no clock edge blanks and restores `seg_q` and leaves the held pattern unchanged.
- R7: Shifting new data with `load_req` low leaves `seg_q` showing the previously loaded pattern until the next load.
- R8: In a chain of two drivers, 2×STAGES shifts place the first STAGES bits sent in the second driver and the last STAGES bits in the first driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and load clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| ser_in | input | 1 | Serial data into stage 1 |
| load_req | input | 1 | Copies the stages into the holding registers at each edge while high |
| show_n | input | 1 | Active-low display enable for all segments |
| seg_q | output | STAGES | Gated segment outputs, bit n-1 for stage n |
| ser_out | output | 1 | Last stage, for chaining |

## Verification
On every cycle, the assertions check the one-stage advance and the entry of serial data. They also check that the serial output trails the second-to-last stage by one edge. For the holding registers, they check that these track the stages when a load is requested and stay still otherwise, and for the segment outputs, that the display enable blanks or passes them. Only the bench scenarios show the end-to-end results: the bit order after a full load, a pattern that stays visible while the next one is shifted in, blanking and restoring with no clock, the delay of the serial output measured against the stimulus, and how data is split across two chained drivers.

// File: rtl/sds_pkg.sv
`timescale 1ns/1ps
package sds_pkg;
  // Default number of shift stages per driver.
  parameter int unsigned SDS_STAGES_DFLT = 12;

  // Fill value used by reset for any width up to 64.
  localparam logic [63:0] SDS_CLEAR = 64'd0;
endpackage

// File: rtl/sds_shift_reg.sv
`timescale 1ns/1ps
module sds_shift_reg #(
  parameter int unsigned STAGES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  output logic [STAGES-1:0] stage_q,
  output logic [STAGES-1:0] stage_nxt
);
  localparam int unsigned TOP = STAGES - 1;

  // Next contents: stage 1 (bit 0) takes the new bit, all others move up.
  function automatic logic [STAGES-1:0] advance(input logic [STAGES-1:0] cur,
                                                input logic             b);
    return {cur[TOP-1:0], b};
  endfunction

  assign stage_nxt = advance(stage_q, bit_in);

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= stage_nxt;
  end

  AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stage_q[TOP:1] == $past(stage_q[TOP-1:0])); // R2
  AST_STAGE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stage_q[0] == $past(bit_in)); // R2
endmodule

// File: rtl/sds_hold_bank.sv
`timescale 1ns/1ps
module sds_hold_bank #(
  parameter int unsigned STAGES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [STAGES-1:0] d_in,
  output logic [STAGES-1:0] hold_q
);
  always_ff @(posedge clk) begin
    if (rst)       hold_q <= '0;
    else if (take) hold_q <= d_in;
  end

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(take) && !$past(rst)) |-> $stable(hold_q)); // R4
endmodule

// File: rtl/sds_out_gate.sv
`timescale 1ns/1ps
module sds_out_gate #(
  parameter int unsigned STAGES = 12
) (
  input  logic              enable_n,
  input  logic [STAGES-1:0] hold_in,
  output logic [STAGES-1:0] seg_out
);
  // One AND gate per segment with the asserted (inverted) enable.
  for (genvar g = 0; g < STAGES; g++) begin : g_and
    assign seg_out[g] = hold_in[g] & ~enable_n;
  end
endmodule

// File: rtl/sds_driver.sv
`timescale 1ns/1ps
module sds_driver #(
  parameter int unsigned STAGES = sds_pkg::SDS_STAGES_DFLT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              load_req,
  input  logic              show_n,
  output logic [STAGES-1:0] seg_q,
  output logic              ser_out
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_nxt;
  logic [STAGES-1:0] hold_q;
  logic              load_evt;
  logic              blank_evt;

  assign load_evt  = load_req;
  assign blank_evt = show_n;

  sds_shift_reg #(.STAGES(STAGES)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .bit_in   (ser_in),
    .stage_q  (stage_q),
    .stage_nxt(stage_nxt)
  );

  sds_hold_bank #(.STAGES(STAGES)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .take  (load_evt),
    .d_in  (stage_nxt),
    .hold_q(hold_q)
  );

  sds_out_gate #(.STAGES(STAGES)) u_gate (
    .enable_n(blank_evt),
    .hold_in (hold_q),
    .seg_out (seg_q)
  );

  assign ser_out = stage_q[TOP];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (stage_q == '0 && hold_q == '0)); // R1
  AST_SOUT_TAIL: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ser_out == $past(stage_q[TOP-1])); // R3
  AST_HOLD_TRACKS: assert property (@(posedge clk) disable iff (rst)
    ($past(load_evt) && !$past(rst)) |-> hold_q == stage_q); // R4
  AST_SEG_BLANKED: assert property (@(posedge clk) disable iff (rst)
    show_n |-> seg_q == '0); // R5
  AST_SEG_PASS: assert property (@(posedge clk) disable iff (rst)
    !show_n |-> seg_q == hold_q); // R5
endmodule

// File: tb/sds_driver_tb.sv
`timescale 1ns/1ps
module sds_driver_tb_top;
  localparam int unsigned N = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic load_req = 1'b0;
  logic show_n = 1'b0;
  logic c_in = 1'b0;
  logic [N-1:0] seg_q, c0_q, c1_q;
  logic ser_out, c0_so, c1_so;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sds_driver #(.STAGES(N)) dut_i (
    .clk(clk), .rst(rst), .ser_in(ser_in), .load_req(load_req),
    .show_n(show_n), .seg_q(seg_q), .ser_out(ser_out));

  sds_driver #(.STAGES(N)) chain0_i (
    .clk(clk), .rst(rst), .ser_in(c_in), .load_req(load_req),
    .show_n(show_n), .seg_q(c0_q), .ser_out(c0_so));

  sds_driver #(.STAGES(N)) chain1_i (
    .clk(clk), .rst(rst), .ser_in(c0_so), .load_req(load_req),
    .show_n(show_n), .seg_q(c1_q), .ser_out(c1_so));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive inputs 1ns after an edge, return 1ns after the next edge.
  task automatic tick(input logic d, input logic le);
    ser_in = d; c_in = d; load_req = le;
    @(posedge clk); #1;
    load_req = 1'b0;
  endtask

  // Shift a pattern msb first; optional load on the last edge.
  task automatic send(input logic [N-1:0] pat, input logic load_last);
    for (int i = N - 1; i >= 0; i--) tick(pat[i], load_last && (i == 0));
  endtask

  task automatic do_reset();
    rst = 1'b1; show_n = 1'b0;
    tick(1'b1, 1'b1); tick(1'b1, 1'b1);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 seg_q after reset", 32'(seg_q), 32'h0);
    chk("R1 ser_out after reset", 32'(ser_out), 32'h0);
  endtask

  task automatic t_load();
    logic [N-1:0] pats [3] = '{12'hA5C, 12'hFFF, 12'h801};
    foreach (pats[k]) begin
      send(pats[k], 1'b1);
      chk("R2 R4 R5 loaded pattern", 32'(seg_q), 32'(pats[k]));
    end
    // Load with a separate pulse after shifting.
    send(12'h3C6, 1'b0);
    tick(1'b1, 1'b1); // shift one more bit and load post-shift contents
    chk("R4 post-shift load", 32'(seg_q), 32'({12'h3C6, 1'b1} & 13'h0FFF));
  endtask

  task automatic t_hold();
    send(12'h0F0, 1'b1);
    send(12'h555, 1'b0);
    chk("R7 old pattern kept while shifting", 32'(seg_q), 32'h0F0);
    tick(1'b0, 1'b0); tick(1'b1, 1'b0);
    chk("R7 old pattern kept", 32'(seg_q), 32'h0F0);
  endtask

  task automatic t_strobe();
    send(12'hC3A, 1'b1);
    show_n = 1'b1; #1;
    chk("R5 blanked", 32'(seg_q), 32'h0);
    show_n = 1'b0; #1;
    chk("R6 restored", 32'(seg_q), 32'hC3A);
    show_n = 1'b1; #0.5; show_n = 1'b0; #0.5;
    chk("R6 restored after glitch", 32'(seg_q), 32'hC3A);
  endtask

  task automatic t_sout();
    logic [7:0] lfsr = 8'h5B;
    logic hist [64];
    do_reset();
    for (int k = 1; k <= 40; k++) begin
      logic b;
      b = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[4], lfsr[7:1]};
      hist[k] = b;
      show_n = lfsr[5];
      tick(b, lfsr[6]);
      if (k < N) chk("R3 ser_out before fill", 32'(ser_out), 32'h0);
      else       chk("R3 ser_out delayed bit", 32'(ser_out), 32'(hist[k-N+1]));
    end
    show_n = 1'b0;
  endtask

  task automatic t_chain();
    logic [2*N-1:0] p = 24'hB1E_4D7;
    do_reset();
    for (int i = 2*N - 1; i >= 0; i--) tick(p[i], i == 0);
    chk("R8 far device holds first bits", 32'(c1_q), 32'(p[2*N-1:N]));
    chk("R8 near device holds last bits", 32'(c0_q), 32'(p[N-1:0]));
  endtask

  initial begin
    t_reset();
    t_load();
    t_hold();
    t_strobe();
    t_sout();
    t_chain();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule